// File: doc/BRIEF.md
# Management-Bus Master for PHY Register Access

This block lets software read and write the registers of an external Ethernet PHY over the two-wire MDIO/MDC management bus. It has four word registers behind a small write strobe and address port. Software first sets the clock divisor and the preamble option in the control register. For a write it loads the data register. It then writes one command word that names the operation, the PHY address and the PHY register. The block latches the command, divides the system clock down to MDC and shifts out one management frame. It sets a busy flag for the whole frame. On a read, the sixteen bits returned by the PHY replace the contents of the data register when busy drops.

MDIO leaves the block as an output value and an output enable. The returned line comes back on its own input pin, so an I/O cell or a pull-up can join the two outside the block. A soft-reset bit in the control register stops any frame in flight. It also restores the block's defaults and clears itself after a fixed number of cycles.

Register map (word address on `reg_addr`): 0 control, 1 command (reads as zero), 2 data, 3 status.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads divisor field 39, preamble-skip 0 and soft-reset 0. Status and data read 0, and mdc and mdio_oe are low.
- R2: A command starts a frame only when exactly one of bit 15 (read) and bit 14 (write) is set. Bits 9:5 give the PHY address and bits 4:0 the register number. A command with both bits set or with neither bit set starts nothing.
- R3: A frame is sent MSB first in this order: 32 ones, start 01, opcode (10 for a read, 01 for a write), 5 PHY address bits, 5 register bits, turnaround, then 16 data bits. On a write the turnaround is 10 and the data is the data register's value at the moment the command was accepted. Each bit is set up at the start of its bit period, while mdc is low.
- R4: The control field at bits 16:9 holds the divisor minus one. Each bit period lasts N = max(field+1, 2) clock cycles. Within a period mdc is low for the first floor(N/2) cycles and high for the rest. The divisor is latched when the command is accepted, so changing it mid-frame has no effect on the frame in flight.
- R5: When control bit 8 is set, the 32-bit preamble is left out and the frame is 32 bits long.
- R6: Status bit 0 reads 1 from the cycle after the command is accepted and stays 1 for exactly (frame bits × N) cycles.
- R7: On a read, mdio_oe is low during the turnaround and the data bits. mdio_i is sampled at each rising edge of mdc. The data register holds the sixteen sampled bits, first bit in bit 15, once busy clears.
- R8: A command written while busy is ignored. The frame in flight continues unchanged, and no second frame follows.
- R9: Writing control with bit 0 set does four things. It aborts any frame, clears the data register, and restores the divisor field to 39 and preamble-skip to 0. Control bit 0 then reads 1 for SRST_CYCLES cycles and 0 after that, and commands written while it reads 1 are ignored.
- R10: Outside a frame, mdc and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register word select (read and write) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W (17) | Register write data |
| reg_rdata | output | REG_W (17) | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The assertions check several properties on every cycle. Mdc and the output enable are quiet outside a frame, and the phase counter never passes the latched divisor. A busy frame keeps its latched command, opcode and divisor until its last bit ends and then drops busy. The soft-reset window counts down one per cycle and holds the engine idle. The bench's scenarios are needed for the rest: the exact bit sequence on mdio_o, the mdc duty split for even, odd and clamped divisors, preamble skipping, the sampling of returned data, and the effect of ignored commands and mid-frame divisor changes as seen at the pins.

// File: rtl/mdio_pkg.sv
// Package: shared register addresses, field positions and frame layout
// for the management-bus master. Assumes a 64-bit frame index space in
// which the optional preamble takes positions 0..31.
package mdio_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CMD  = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_STAT = 2'd3
    } reg_sel_e;

    localparam int CMD_RD_BIT    = 15;
    localparam int CMD_WR_BIT    = 14;
    localparam int CMD_PHY_LSB   = 5;
    localparam int CMD_REG_LSB   = 0;
    localparam int CTRL_SRST_BIT = 0;
    localparam int CTRL_PRE_BIT  = 8;
    localparam int CTRL_DIV_LSB  = 9;
    localparam int DATA_W        = 16;

    localparam logic [5:0] IDX_BODY = 6'd32;
    localparam logic [5:0] IDX_TA   = 6'd46;
    localparam logic [5:0] IDX_DATA = 6'd48;
    localparam logic [5:0] IDX_LAST = 6'd63;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
// Module: bit-period phase counter. While run is high, it counts
// 0..div_m1 and wraps. It flags the last cycle of each bit period and the
// cycle just before mdc rises. Assumes div_m1 >= 1 and holds still while
// run is high.
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             mdc_hi,
    output logic             bit_end,
    output logic             sample_pt
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   n_val;
    logic [DIV_W:0]   half;
    logic [DIV_W:0]   cnt_ext;

    // Derive the period length and the low-phase length from the divisor.
    always_comb begin
        n_val   = {1'b0, div_m1} + 1'b1;
        half    = n_val >> 1;
        cnt_ext = {1'b0, cnt};
    end

    // Advance the phase counter and wrap it at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == div_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc_hi    = run && (cnt_ext >= half);
    assign bit_end   = run && (cnt == div_m1);
    assign sample_pt = run && (cnt_ext == half - 1'b1);

    assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div_m1));
endmodule

// File: rtl/mdio_engine.sv
// Module: frame sequencer. On start it latches the command, the write
// data, the preamble choice and the divisor. It then walks a bit index
// across the frame and drives mdio_o and mdio_oe. On a read it shifts in
// mdio_i at each mdc rise. Assumes start never comes while busy or
// together with abort.
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic              start_read,
    input  logic [4:0]        phy,
    input  logic [4:0]        regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pre_skip,
    input  logic [DIV_W-1:0]  div_m1_in,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    logic              busy_q;
    logic              read_q;
    logic [5:0]        idx;
    logic [31:0]       frame_q;
    logic [DIV_W-1:0]  div_lat;
    logic [DATA_W-1:0] rsh;
    logic              mdc_hi;
    logic              bit_end;
    logic              sample_pt;
    logic              is_last;
    logic              body_bit;
    logic              released;

    mdio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_q),
        .div_m1    (div_lat),
        .mdc_hi    (mdc_hi),
        .bit_end   (bit_end),
        .sample_pt (sample_pt)
    );

    // Select the current frame bit and decide whether the master drives it.
    always_comb begin
        is_last  = (idx == IDX_LAST);
        body_bit = frame_q[5'd31 - idx[4:0]];
        released = read_q && (idx >= IDX_TA);
    end

    assign busy    = busy_q;
    assign mdc     = mdc_hi;
    assign mdio_o  = busy_q && (idx[5] ? body_bit : 1'b1);
    assign mdio_oe = busy_q && !released;
    assign rd_done = busy_q && read_q && bit_end && is_last && !abort;
    assign rd_data = rsh;

    // Latch a command, step through the frame and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            read_q  <= 1'b0;
            idx     <= '0;
            frame_q <= '0;
            div_lat <= DIV_W'(1);
            rsh     <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            read_q  <= start_read;
            idx     <= pre_skip ? IDX_BODY : 6'd0;
            div_lat <= div_m1_in;
            rsh     <= '0;
            frame_q <= start_read ? {SOF_BITS, OP_READ, phy, regad, 2'b00, 16'h0000}
                                  : {SOF_BITS, OP_WRITE, phy, regad, TA_DRIVE, wdata};
        end else if (busy_q) begin
            if (sample_pt && read_q && (idx >= IDX_DATA)) begin
                rsh <= {rsh[DATA_W-2:0], mdio_i};
            end
            if (bit_end) begin
                if (is_last) begin
                    busy_q <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (!mdc_hi && !mdio_oe));

    assert_cmd_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !abort && !(bit_end && is_last))
            |=> ($stable(frame_q) && $stable(read_q) && $stable(div_lat) && busy_q));

    assert_frame_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && bit_end && is_last && !abort) |=> !busy_q);
endmodule

// File: rtl/mdio_regs.sv
// Module: register file. It decodes writes to control, command and data.
// It qualifies commands (exactly one operation bit, engine idle, no soft
// reset pending), runs the soft-reset countdown and muxes register reads.
// Assumes one register write per cycle.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DIV_DEFAULT = 39,
    parameter int SRST_CYCLES = 4,
    parameter int REG_W       = CTRL_DIV_LSB + DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output logic              start_read,
    output logic [4:0]        phy,
    output logic [4:0]        regad,
    output logic [DATA_W-1:0] wr_data,
    output logic              pre_skip,
    output logic [DIV_W-1:0]  div_m1_eff,
    output logic              srst_req,
    output logic              srst_active
);
    localparam int SC_W = $clog2(SRST_CYCLES + 1);

    logic [DIV_W-1:0]  div_q;
    logic              pre_q;
    logic [DATA_W-1:0] data_q;
    logic [SC_W-1:0]   srst_cnt;
    logic              wr_ctrl;
    logic              wr_cmd;
    logic              wr_dreg;
    logic              one_op;

    // Decode the write strobe per register and qualify a command.
    always_comb begin
        wr_ctrl = reg_we && (reg_sel_e'(reg_addr) == ADDR_CTRL);
        wr_cmd  = reg_we && (reg_sel_e'(reg_addr) == ADDR_CMD);
        wr_dreg = reg_we && (reg_sel_e'(reg_addr) == ADDR_DATA);
        one_op  = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
    end

    assign srst_req    = wr_ctrl && reg_wdata[CTRL_SRST_BIT];
    assign srst_active = (srst_cnt != '0);
    assign start       = wr_cmd && one_op && !eng_busy && !srst_active;
    assign start_read  = reg_wdata[CMD_RD_BIT];
    assign phy         = reg_wdata[CMD_PHY_LSB +: 5];
    assign regad       = reg_wdata[CMD_REG_LSB +: 5];
    assign wr_data     = data_q;
    assign pre_skip    = pre_q;
    assign div_m1_eff  = (div_q == '0) ? DIV_W'(1) : div_q;

    // Hold control fields and run the self-clearing soft-reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= DIV_W'(DIV_DEFAULT);
            pre_q    <= 1'b0;
            srst_cnt <= '0;
        end else if (srst_req) begin
            div_q    <= DIV_W'(DIV_DEFAULT);
            pre_q    <= 1'b0;
            srst_cnt <= SC_W'(SRST_CYCLES);
        end else begin
            if (srst_active) begin
                srst_cnt <= srst_cnt - 1'b1;
            end
            if (wr_ctrl) begin
                div_q <= reg_wdata[CTRL_DIV_LSB +: DIV_W];
                pre_q <= reg_wdata[CTRL_PRE_BIT];
            end
        end
    end

    // Keep the data register: soft reset, then read result, then software.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_req) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_data;
        end else if (wr_dreg) begin
            data_q <= reg_wdata[DATA_W-1:0];
        end
    end

    // Drive the read data for the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            ADDR_CTRL: begin
                reg_rdata[CTRL_DIV_LSB +: DIV_W] = div_q;
                reg_rdata[CTRL_PRE_BIT]          = pre_q;
                reg_rdata[CTRL_SRST_BIT]         = srst_active;
            end
            ADDR_DATA: reg_rdata[DATA_W-1:0] = data_q;
            ADDR_STAT: reg_rdata[0]          = eng_busy;
            default:   reg_rdata             = '0;
        endcase
    end

    assert_srst_idles_engine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |-> !eng_busy);

    assert_srst_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_active && !srst_req) |=> (srst_cnt == $past(srst_cnt) - 1'b1));
endmodule

// File: rtl/mdio_master.sv
// Module: top of the management-bus master. It joins the register file
// to the frame engine. Assumes that an external I/O cell merges mdio_o
// and mdio_oe with mdio_i, and that the line is pulled high when released.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DIV_DEFAULT = 39,
    parameter int SRST_CYCLES = 4,
    localparam int REG_W      = CTRL_DIV_LSB + DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic              eng_busy;
    logic              rd_done;
    logic [DATA_W-1:0] rd_data;
    logic              start;
    logic              start_read;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [DATA_W-1:0] wr_data;
    logic              pre_skip;
    logic [DIV_W-1:0]  div_m1_eff;
    logic              srst_req;
    logic              srst_active;

    mdio_regs #(
        .DIV_W       (DIV_W),
        .DIV_DEFAULT (DIV_DEFAULT),
        .SRST_CYCLES (SRST_CYCLES),
        .REG_W       (REG_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .eng_busy    (eng_busy),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .start       (start),
        .start_read  (start_read),
        .phy         (phy),
        .regad       (regad),
        .wr_data     (wr_data),
        .pre_skip    (pre_skip),
        .div_m1_eff  (div_m1_eff),
        .srst_req    (srst_req),
        .srst_active (srst_active)
    );

    mdio_engine #(.DIV_W(DIV_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (srst_req || srst_active),
        .start      (start),
        .start_read (start_read),
        .phy        (phy),
        .regad      (regad),
        .wdata      (wr_data),
        .pre_skip   (pre_skip),
        .div_m1_in  (div_m1_eff),
        .mdio_i     (mdio_i),
        .busy       (eng_busy),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/mdio_master_test.sv
// Bench: behavioural reference model of the frame timing, checked against
// mdc, mdio_oe and mdio_o on every falling clock edge, plus register reads.
module mdio_master_test;
    localparam int SRST = 4;
    localparam int DEF_DIV = 39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic        reg_we = 1'b0;
    logic [16:0] reg_wdata = '0;
    logic [16:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit chk_on = 0;

    // reference model state
    bit          m_active = 0, m_read = 0, m_pre = 0;
    int          m_div = DEF_DIV, m_n = 40, m_s = 0, m_len = 64;
    int          t0 = 0, ts = -1000;
    logic [4:0]  m_phy = '0, m_reg = '0;
    logic [15:0] m_wd = '0, m_data = '0, m_phyval = '0, phy_val = '0;

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit frame_bit(int pos);
        logic [31:0] body;
        body = {2'b01, (m_read ? 2'b10 : 2'b01), m_phy, m_reg,
                (m_read ? 2'b00 : 2'b10), (m_read ? 16'h0000 : m_wd)};
        if (pos < 32) return 1'b1;
        return body[63 - pos];
    endfunction

    // Model step, PHY drive and pin comparison on each falling edge.
    always @(negedge clk) begin
        int k, pos, ph;
        bit e_mdc, e_oe, e_o;
        if (chk_on) begin
            k = cyc - t0;
            if (m_active && k >= m_len * m_n) begin
                m_active = 0;
                if (m_read) m_data = m_phyval;
            end
            e_mdc = 0; e_oe = 0; e_o = 0; mdio_i = 1'b1;
            if (m_active) begin
                pos   = m_s + k / m_n;
                ph    = k % m_n;
                e_mdc = (ph >= m_n / 2);
                e_oe  = !(m_read && pos >= 46);
                e_o   = frame_bit(pos);
                if (m_read && pos >= 48) mdio_i = m_phyval[63 - pos];
            end
            check("R4", "mdc", int'(mdc), int'(e_mdc));
            check(m_active ? "R7" : "R10", "mdio_oe", int'(mdio_oe), int'(e_oe));
            if (e_oe) check("R3", "mdio_o", int'(mdio_o), int'(e_o));
        end
    end

    task automatic write_reg(logic [1:0] a, logic [16:0] d);
        int kp;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        reg_addr = 2'd3;
        if (a == 2'd0) begin
            if (d[0]) begin
                m_active = 0; ts = cyc; m_div = DEF_DIV; m_pre = 0; m_data = '0;
            end else begin
                m_div = int'(d[16:9]); m_pre = d[8];
            end
        end else if (a == 2'd2) begin
            m_data = d[15:0];
        end else if (a == 2'd1) begin
            kp = (cyc - 1) - ts;
            if (!m_active && !(kp >= 0 && kp < SRST) && (d[15] ^ d[14])) begin
                m_active = 1; t0 = cyc; m_read = d[15];
                m_phy = d[9:5]; m_reg = d[4:0]; m_wd = m_data; m_phyval = phy_val;
                m_n = (m_div + 1 < 2) ? 2 : m_div + 1;
                m_s = m_pre ? 32 : 0; m_len = 64 - m_s;
            end
        end
    endtask

    task automatic read_check(logic [1:0] a, string req, string what);
        int exp, k;
        @(negedge clk);
        reg_addr = a;
        #1;
        k = cyc - ts;
        case (a)
            2'd0: exp = (m_div << 9) | (int'(m_pre) << 8) | ((k >= 0 && k < SRST) ? 1 : 0);
            2'd2: exp = int'(m_data);
            2'd3: exp = int'(m_active);
            default: exp = 0;
        endcase
        check(req, what, int'(reg_rdata), exp);
        reg_addr = 2'd3;
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        // R1: reset values
        read_check(2'd0, "R1", "control after reset");
        read_check(2'd3, "R1", "status after reset");
        read_check(2'd2, "R1", "data after reset");
        check("R1", "mdc after reset", int'(mdc), 0);

        // R3 R6: write frame, divide by 4
        write_reg(2'd0, 17'(3 << 9));
        write_reg(2'd2, 17'h0A5C3);
        write_reg(2'd1, 17'((1 << 14) | (5 << 5) | 5'h1A));
        repeat (30) @(negedge clk);
        read_check(2'd3, "R6", "busy mid-frame");
        wait_idle();
        read_check(2'd3, "R6", "busy after write frame");

        // R7: read frame, odd divisor 5
        write_reg(2'd0, 17'(4 << 9));
        phy_val = 16'hBEEF;
        write_reg(2'd1, 17'((1 << 15) | (31 << 5) | 3));
        wait_idle();
        read_check(2'd2, "R7", "read data odd divisor");

        // R5 R4: preamble skipped, divisor field 0 clamps to 2
        write_reg(2'd0, 17'(1 << 8));
        phy_val = 16'h1234;
        write_reg(2'd1, 17'((1 << 15) | (1 << 5) | 2));
        wait_idle();
        read_check(2'd2, "R5", "read data short frame");

        // R2: both op bits, then no op bit
        write_reg(2'd0, 17'(2 << 9));
        write_reg(2'd1, 17'h0C000 | 17'(3 << 5));
        repeat (3) @(negedge clk);
        read_check(2'd3, "R2", "both op bits start nothing");
        write_reg(2'd1, 17'(7 << 5) | 17'd9);
        repeat (3) @(negedge clk);
        read_check(2'd3, "R2", "no op bit starts nothing");

        // R8 R4: command and divisor change during a frame
        write_reg(2'd2, 17'h00F0F);
        write_reg(2'd1, 17'((1 << 14) | (2 << 5) | 4));
        repeat (40) @(negedge clk);
        phy_val = 16'h5555;
        write_reg(2'd1, 17'((1 << 15) | (9 << 5) | 1));
        write_reg(2'd0, 17'(7 << 9));
        wait_idle();
        repeat (20) @(negedge clk);
        read_check(2'd3, "R8", "no second frame after ignored command");
        read_check(2'd2, "R8", "data untouched by ignored read");

        // R9: soft reset during a read frame
        write_reg(2'd0, 17'(3 << 9));
        phy_val = 16'hFFFF;
        write_reg(2'd1, 17'((1 << 15) | (4 << 5) | 6));
        repeat (100) @(negedge clk);
        write_reg(2'd0, 17'(5 << 9) | 17'd1);
        read_check(2'd0, "R9", "control during soft reset");
        write_reg(2'd1, 17'((1 << 14) | (3 << 5) | 3));
        read_check(2'd3, "R9", "command ignored in soft reset");
        repeat (6) @(negedge clk);
        read_check(2'd0, "R9", "control after soft reset");
        read_check(2'd2, "R9", "data cleared by soft reset");

        // R4: default divide by 40
        write_reg(2'd2, 17'h08001);
        write_reg(2'd1, 17'((1 << 14) | 5'h1F));
        wait_idle();
        read_check(2'd3, "R6", "idle after default-divisor frame");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule